// File: doc/BRIEF.md
# Interrupt and Halt Request Arbiter

This block decides what a small 8-bit processor sequencer does next at each instruction boundary. When the sequencer marks the final cycle of an instruction, the block looks at the halt request and the three interrupt request inputs. It then either names a service action or tells the sequencer to carry on. The block also holds the interrupt mask flags. It captures edges on the non-maskable request and clears that request through an acknowledge handshake. It keeps the non-maskable request blocked after reset until the system stack pointer has been written. It keeps the vector code register and forms the vector address from that code.

A wait-for-interrupt mode lets the sequencer park until a request arrives. A request that is not masked is serviced through its vector. A request that is masked only releases the wait, and the vector code is not touched. A halt request parks the block in a halted state that frees the bus. Leaving that state resumes the sequencer at its decode step. All requests and outputs are plain level signals, because nothing streams through this block. The action code is combinational and is valid in the same cycle as the inputs. It commits at the next rising edge unless hold is high.

Top module: `irq_halt_arbiter`

## Requirements
- R1: While rst is high, the following are forced at each clock edge: vector code 3'b111 (so vec_addr is 16'hFFFE), flags 8'hD0, halted low, and the non-maskable request, its acknowledge and its enable all cleared.
- R2: When the block is not halted and neither insn_last nor sync_wait is high, act is 0 (continue), whatever the request inputs are.
- R3: At a boundary (insn_last high, not halted) the action is chosen in this order: halt_req gives act 1, then a pending non-maskable request gives act 2, then the fast request gives act 3, then the normal request gives act 4, and otherwise act is 0.
- R4: The fast and normal requests are level sensitive. The fast request is masked by flags bit 6, and the normal request is masked by flags bit 4.
- R5: A non-maskable input is not captured until sp_full_load or sp_lo_pull has been seen since the last reset.
- R6: A non-maskable input that is high while enabled and not acknowledged is latched, and it stays pending after the input falls. nmi_mask_step acknowledges it. A request that stays high is not taken again; a new request needs the input to go low and then rise again.
- R7: A committed act 2, 3 or 4 loads vector code 110, 011 or 100. swi_req with swi_kind 1, 2 or 3 loads 101, 010 or 001, and swi_kind 0 loads nothing. vec_addr is 16'hFFF0 plus twice the code.
- R8: With sync_wait high, a request that is not masked is serviced as in R3. A fast or normal request that is masked gives act 5 (resume) and leaves the vector code unchanged. No request at all gives act 6 (wait).
- R9: A committed act 1 sets halted. While halted, bus_avail and bus_status are high and act is 6 while halt_req stays high. Once halt_req falls, act is 7 (resume at decode) and halted clears at that edge.
- R10: With hold high, no register changes at the edge: flags, vector code, halted and the non-maskable latch keep their values.
- R11: bus_status is high during a vector fetch (vec_fetch high) or while halted. bus_avail is high while halted or while sync_wait is high.
- R12: flags_load writes flags_wdata into the flags at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Stalls every register for the cycle |
| insn_last | input | 1 | Final cycle of the current instruction |
| sync_wait | input | 1 | Sequencer is parked in wait-for-interrupt |
| halt_req | input | 1 | Halt request |
| nmi_in | input | 1 | Non-maskable request input |
| firq_in | input | 1 | Fast request, level |
| irq_in | input | 1 | Normal request, level |
| sp_full_load | input | 1 | System stack pointer fully written |
| sp_lo_pull | input | 1 | Stack pointer low byte pulled from memory |
| nmi_mask_step | input | 1 | Sequencer is at the non-maskable masking step |
| swi_req | input | 1 | Software interrupt vector load |
| swi_kind | input | 2 | Software interrupt variant, 1 to 3 |
| flags_load | input | 1 | Write strobe for the flags |
| flags_wdata | input | 8 | New flags value |
| vec_fetch | input | 1 | Vector fetch bus cycle in progress |
| act | output | 3 | Action code, see R2, R3, R8 and R9 |
| vec_code | output | 3 | Vector code register |
| vec_addr | output | 16 | Vector address for the high byte fetch |
| flags_q | output | 8 | Flags including the mask bits |
| nmi_pending | output | 1 | Non-maskable request latched and not acknowledged |
| halted | output | 1 | Halted state |
| bus_avail | output | 1 | Bus free for another master |
| bus_status | output | 1 | Vector fetch or halt in progress |

## Verification
The boundary decision is tried with all request inputs high and then with fewer and fewer of them. This shows that halt wins over the others, that a pending non-maskable request wins over the fast request, and that the fast request wins over the normal one. The same request set is then applied under each mask value, which separates masking from priority. For the non-maskable input, a short pulse is applied before and after the stack pointer enable, then a level held across the acknowledge, then a fresh edge. This separates the enable gate, edge capture and the handshake. In wait mode, masked, unmasked and absent requests are applied; the vector code is read back afterwards, which tells resume apart from service.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

  typedef enum logic [2:0] {
    ACT_NEXT   = 3'd0,
    ACT_HALT   = 3'd1,
    ACT_NMI    = 3'd2,
    ACT_FIRQ   = 3'd3,
    ACT_IRQ    = 3'd4,
    ACT_RESUME = 3'd5,
    ACT_WAIT   = 3'd6,
    ACT_DECODE = 3'd7
  } arb_act_e;

  localparam logic [2:0] VC_RESET = 3'b111;
  localparam logic [2:0] VC_NMI   = 3'b110;
  localparam logic [2:0] VC_SWI1  = 3'b101;
  localparam logic [2:0] VC_IRQ   = 3'b100;
  localparam logic [2:0] VC_FIRQ  = 3'b011;
  localparam logic [2:0] VC_SWI2  = 3'b010;
  localparam logic [2:0] VC_SWI3  = 3'b001;

  function automatic logic act_is_take(input arb_act_e a);
    return (a == ACT_NMI) || (a == ACT_FIRQ) || (a == ACT_IRQ);
  endfunction

  function automatic logic [2:0] act_to_code(input arb_act_e a);
    case (a)
      ACT_NMI:  return VC_NMI;
      ACT_FIRQ: return VC_FIRQ;
      default:  return VC_IRQ;
    endcase
  endfunction

endpackage

// File: rtl/irqarb_nmi_gate.sv
module irqarb_nmi_gate (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic nmi_in,
  input  logic sp_full_load,
  input  logic sp_lo_pull,
  input  logic mask_step,
  output logic pending
);
  logic enable_q, req_q, ack_q;

  // enable flag: opened by stack pointer writes
  always_ff @(posedge clk) begin
    if (rst) enable_q <= 1'b0;
    else if (!hold && (sp_full_load || sp_lo_pull)) enable_q <= 1'b1;
  end

  // request latch: set on a high input, cleared only after ack and a low input
  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else if (!hold) begin
      if (nmi_in && !ack_q && enable_q) req_q <= 1'b1;
      else if (!nmi_in && ack_q)        req_q <= 1'b0;
    end
  end

  // acknowledge: taken at the masking step, released once the request drops
  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else if (!hold) begin
      if (req_q && !ack_q && mask_step) ack_q <= 1'b1;
      else if (!req_q && ack_q)         ack_q <= 1'b0;
    end
  end

  assign pending = req_q && !ack_q;
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int FBIT   = 6,
  parameter int IBIT   = 4
) (
  input  logic              halted,
  input  logic              insn_last,
  input  logic              sync_wait,
  input  logic              halt_req,
  input  logic              nmi_pending,
  input  logic              firq_in,
  input  logic              irq_in,
  input  logic [FLAG_W-1:0] flags,
  output arb_act_e          act
);
  logic eval, firq_ok, irq_ok, any_lvl;

  assign eval    = insn_last || sync_wait;
  assign firq_ok = firq_in && !flags[FBIT];
  assign irq_ok  = irq_in && !flags[IBIT];
  assign any_lvl = firq_in || irq_in;

  always_comb begin
    act = ACT_NEXT;
    if (halted)            act = halt_req ? ACT_WAIT : ACT_DECODE;
    else if (!eval)        act = ACT_NEXT;
    else if (halt_req)     act = ACT_HALT;
    else if (nmi_pending)  act = ACT_NMI;
    else if (firq_ok)      act = ACT_FIRQ;
    else if (irq_ok)       act = ACT_IRQ;
    else if (sync_wait)    act = any_lvl ? ACT_RESUME : ACT_WAIT;
    else                   act = ACT_NEXT;
  end
endmodule

// File: rtl/irqarb_vector.sv
module irqarb_vector
  import irqarb_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  arb_act_e          act,
  input  logic              swi_req,
  input  logic [1:0]        swi_kind,
  output logic [2:0]        code,
  output logic [ADDR_W-1:0] addr
);
  localparam int OFS_W = 4;
  logic [2:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= VC_RESET;
    else if (!hold) begin
      if (act_is_take(act)) code_q <= act_to_code(act);
      else if (swi_req) begin
        case (swi_kind)
          2'd1:    code_q <= VC_SWI1;
          2'd2:    code_q <= VC_SWI2;
          2'd3:    code_q <= VC_SWI3;
          default: code_q <= code_q;
        endcase
      end
    end
  end

  assign code = code_q;
  assign addr = ADDR_W'(VEC_BASE) + ADDR_W'({{(OFS_W-3){1'b0}}, code_q, 1'b0});
endmodule

// File: rtl/irqarb_flags.sv
module irqarb_flags #(
  parameter int              FLAG_W   = 8,
  parameter logic [FLAG_W-1:0] FLAG_RST = 8'hD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              load,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)               q <= FLAG_RST;
    else if (!hold && load) q <= wdata;
  end
endmodule

// File: rtl/irq_halt_arbiter.sv
module irq_halt_arbiter
  import irqarb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              insn_last,
  input  logic              sync_wait,
  input  logic              halt_req,
  input  logic              nmi_in,
  input  logic              firq_in,
  input  logic              irq_in,
  input  logic              sp_full_load,
  input  logic              sp_lo_pull,
  input  logic              nmi_mask_step,
  input  logic              swi_req,
  input  logic [1:0]        swi_kind,
  input  logic              flags_load,
  input  logic [FLAG_W-1:0] flags_wdata,
  input  logic              vec_fetch,
  output logic [2:0]        act,
  output logic [2:0]        vec_code,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [FLAG_W-1:0] flags_q,
  output logic              nmi_pending,
  output logic              halted,
  output logic              bus_avail,
  output logic              bus_status
);
  arb_act_e act_w;
  logic     halted_q;

  irqarb_flags #(.FLAG_W(FLAG_W), .FLAG_RST(FLAG_W'(8'hD0))) u_flags (
    .clk(clk), .rst(rst), .hold(hold), .load(flags_load),
    .wdata(flags_wdata), .q(flags_q)
  );

  irqarb_nmi_gate u_nmi (
    .clk(clk), .rst(rst), .hold(hold), .nmi_in(nmi_in),
    .sp_full_load(sp_full_load), .sp_lo_pull(sp_lo_pull),
    .mask_step(nmi_mask_step), .pending(nmi_pending)
  );

  irqarb_select #(.FLAG_W(FLAG_W), .FBIT(6), .IBIT(4)) u_sel (
    .halted(halted_q), .insn_last(insn_last), .sync_wait(sync_wait),
    .halt_req(halt_req), .nmi_pending(nmi_pending), .firq_in(firq_in),
    .irq_in(irq_in), .flags(flags_q), .act(act_w)
  );

  irqarb_vector #(.ADDR_W(ADDR_W), .VEC_BASE(16'hFFF0)) u_vec (
    .clk(clk), .rst(rst), .hold(hold), .act(act_w), .swi_req(swi_req),
    .swi_kind(swi_kind), .code(vec_code), .addr(vec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) halted_q <= 1'b0;
    else if (!hold) begin
      if (act_w == ACT_HALT)        halted_q <= 1'b1;
      else if (act_w == ACT_DECODE) halted_q <= 1'b0;
    end
  end

  assign act        = act_w;
  assign halted     = halted_q;
  assign bus_avail  = halted_q || sync_wait;
  assign bus_status = halted_q || vec_fetch;
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker (
  input logic       clk,
  input logic       rst,
  input logic       hold,
  input logic       insn_last,
  input logic       sync_wait,
  input logic       halt_req,
  input logic       firq_in,
  input logic       irq_in,
  input logic       nmi_pending,
  input logic [2:0] act,
  input logic [2:0] vec_code,
  input logic [7:0] flags_q,
  input logic       halted,
  input logic       bus_avail,
  input logic       bus_status
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (vec_code == 3'b111) && (flags_q == 8'hD0) && !halted);

  a_r2_idle_next: assert property (@(posedge clk) disable iff (rst)
    (!insn_last && !sync_wait && !halted) |-> (act == 3'd0));

  a_r3_halt_first: assert property (@(posedge clk) disable iff (rst)
    (insn_last && !halted && halt_req) |-> (act == 3'd1));

  a_r4_masked_levels: assert property (@(posedge clk) disable iff (rst)
    (insn_last && !sync_wait && !halted && !halt_req && !nmi_pending &&
     flags_q[6] && flags_q[4]) |-> (act == 3'd0));

  a_r8_masked_sync_keeps_vec: assert property (@(posedge clk) disable iff (rst)
    (act == 3'd5 && !hold) |=> $stable(vec_code));

  a_r9_halt_bus: assert property (@(posedge clk) disable iff (rst)
    halted |-> (bus_avail && bus_status));

  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(vec_code) && $stable(flags_q) && $stable(halted)));
endmodule

bind irq_halt_arbiter irqarb_checker u_chk (
  .clk(clk), .rst(rst), .hold(hold), .insn_last(insn_last),
  .sync_wait(sync_wait), .halt_req(halt_req), .firq_in(firq_in),
  .irq_in(irq_in), .nmi_pending(nmi_pending), .act(act),
  .vec_code(vec_code), .flags_q(flags_q), .halted(halted),
  .bus_avail(bus_avail), .bus_status(bus_status)
);

// File: tb/irq_halt_arbiter_test.sv
module irq_halt_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold, insn_last, sync_wait, halt_req, nmi_in, firq_in, irq_in;
  logic sp_full_load, sp_lo_pull, nmi_mask_step, swi_req, flags_load, vec_fetch;
  logic [1:0]  swi_kind;
  logic [7:0]  flags_wdata;
  logic [2:0]  act, vec_code;
  logic [15:0] vec_addr;
  logic [7:0]  flags_q;
  logic nmi_pending, halted, bus_avail, bus_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_halt_arbiter uut (
    .clk(clk), .rst(rst), .hold(hold), .insn_last(insn_last),
    .sync_wait(sync_wait), .halt_req(halt_req), .nmi_in(nmi_in),
    .firq_in(firq_in), .irq_in(irq_in), .sp_full_load(sp_full_load),
    .sp_lo_pull(sp_lo_pull), .nmi_mask_step(nmi_mask_step),
    .swi_req(swi_req), .swi_kind(swi_kind), .flags_load(flags_load),
    .flags_wdata(flags_wdata), .vec_fetch(vec_fetch), .act(act),
    .vec_code(vec_code), .vec_addr(vec_addr), .flags_q(flags_q),
    .nmi_pending(nmi_pending), .halted(halted), .bus_avail(bus_avail),
    .bus_status(bus_status)
  );

  typedef struct {
    int act; int vec; int addr; int flg; int hlt; int ba; int bs;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // driver side: push an expectation for the current cycle (-1 = not checked)
  task automatic want(input int a, input int v, input int ad, input int f,
                      input int h, input int ba, input int bs, input string tag);
    exp_t e;
    e.act = a; e.vec = v; e.addr = ad; e.flg = f; e.hlt = h; e.ba = ba; e.bs = bs;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic nxt();
    @(negedge clk);
    rst = 0; hold = 0; insn_last = 0; sync_wait = 0; halt_req = 0; nmi_in = 0;
    firq_in = 0; irq_in = 0; sp_full_load = 0; sp_lo_pull = 0;
    nmi_mask_step = 0; swi_req = 0; swi_kind = 0; flags_load = 0;
    flags_wdata = 0; vec_fetch = 0;
  endtask

  function automatic void cmp(input string tag, input string fld,
                              input int got, input int exp);
    if (exp < 0) return;
    n_vec++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, fld, got, exp);
    end
  endfunction

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    #2;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      cmp(e.tag, "act", int'(act), e.act);
      cmp(e.tag, "vec_code", int'(vec_code), e.vec);
      cmp(e.tag, "vec_addr", int'(vec_addr), e.addr);
      cmp(e.tag, "flags", int'(flags_q), e.flg);
      cmp(e.tag, "halted", int'(halted), e.hlt);
      cmp(e.tag, "bus_avail", int'(bus_avail), e.ba);
      cmp(e.tag, "bus_status", int'(bus_status), e.bs);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    hold = 0; insn_last = 0; sync_wait = 0; halt_req = 0; nmi_in = 0;
    firq_in = 0; irq_in = 0; sp_full_load = 0; sp_lo_pull = 0;
    nmi_mask_step = 0; swi_req = 0; swi_kind = 0; flags_load = 0;
    flags_wdata = 0; vec_fetch = 0;
    repeat (3) @(negedge clk);
    nxt(); want(0, 7, 'hFFFE, 'hD0, 0, 0, 0, "R1 reset state");
    nxt(); flags_load = 1; flags_wdata = 8'h00; want(0, -1, -1, 'hD0, -1, -1, -1, "R12 pre-load");
    nxt(); irq_in = 1; firq_in = 1; halt_req = 1;
           want(0, -1, -1, 'h00, 0, -1, -1, "R2 no boundary, R12 loaded");
    nxt(); insn_last = 1; halt_req = 1; firq_in = 1; irq_in = 1;
           want(1, -1, -1, -1, 0, -1, -1, "R3 halt first");
    nxt(); halt_req = 1; want(6, -1, -1, -1, 1, 1, 1, "R9 halted wait");
    nxt(); insn_last = 1; firq_in = 1; want(7, -1, -1, -1, 1, 1, 1, "R9 leave halt");
    nxt(); insn_last = 1; firq_in = 1; irq_in = 1;
           want(3, -1, -1, -1, 0, 0, 0, "R3 fast over normal");
    nxt(); insn_last = 1; irq_in = 1; want(4, 3, 'hFFF6, -1, -1, -1, -1, "R7 fast vector");
    nxt(); flags_load = 1; flags_wdata = 8'h40; want(0, 4, 'hFFF8, -1, -1, -1, -1, "R7 normal vector");
    nxt(); insn_last = 1; firq_in = 1; irq_in = 1; want(4, -1, -1, 'h40, -1, -1, -1, "R4 fast masked");
    nxt(); flags_load = 1; flags_wdata = 8'h50;
    nxt(); insn_last = 1; firq_in = 1; irq_in = 1; want(0, 4, -1, 'h50, -1, -1, -1, "R4 both masked");
    nxt(); nmi_in = 1;
    nxt(); insn_last = 1; want(0, -1, -1, -1, -1, -1, -1, "R5 nmi blocked before enable");
    nxt(); sp_lo_pull = 1;
    nxt(); nmi_in = 1; flags_load = 1; flags_wdata = 8'h00;
    nxt(); insn_last = 1; firq_in = 1; irq_in = 1;
           want(2, -1, -1, 'h00, -1, -1, -1, "R6 pulse captured, R3 nmi over fast");
    nxt(); nmi_mask_step = 1; nmi_in = 1; want(0, 6, 'hFFFC, -1, -1, -1, -1, "R7 nmi vector");
    nxt(); nmi_in = 1; insn_last = 1; want(0, -1, -1, -1, -1, -1, -1, "R6 held level not retaken");
    nxt(); nmi_in = 0;
    nxt(); nmi_in = 0;
    nxt(); nmi_in = 1;
    nxt(); insn_last = 1; want(2, -1, -1, -1, -1, -1, -1, "R6 new edge taken");
    nxt(); nmi_mask_step = 1;
    nxt();
    nxt();
    nxt(); flags_load = 1; flags_wdata = 8'h10;
    nxt(); sync_wait = 1; irq_in = 1; want(5, 6, -1, 'h10, -1, 1, -1, "R8 masked resume, R11 sync bus");
    nxt(); sync_wait = 1; want(6, 6, -1, -1, -1, -1, -1, "R8 wait, vector kept");
    nxt(); sync_wait = 1; firq_in = 1; want(3, -1, -1, -1, -1, -1, -1, "R8 unmasked serviced");
    nxt(); swi_req = 1; swi_kind = 2'd1; want(-1, 3, 'hFFF6, -1, -1, -1, -1, "R8 sync vector loaded");
    nxt(); swi_req = 1; swi_kind = 2'd2; want(-1, 5, 'hFFFA, -1, -1, -1, -1, "R7 swi1");
    nxt(); swi_req = 1; swi_kind = 2'd3; want(-1, 2, 'hFFF4, -1, -1, -1, -1, "R7 swi2");
    nxt(); swi_req = 1; swi_kind = 2'd0; want(-1, 1, 'hFFF2, -1, -1, -1, -1, "R7 swi3");
    nxt(); hold = 1; swi_req = 1; swi_kind = 2'd1; flags_load = 1; flags_wdata = 8'hFF;
           insn_last = 1; halt_req = 1; want(-1, 1, 'hFFF2, -1, -1, -1, -1, "R7 kind 0 ignored");
    nxt(); want(-1, 1, 'hFFF2, 'h10, 0, 0, 0, "R10 hold froze state");
    nxt(); vec_fetch = 1; want(0, -1, -1, -1, 0, 0, 1, "R11 vector fetch status");
    nxt(); rst = 1;
    nxt(); want(0, 7, 'hFFFE, 'hD0, 0, 0, 0, "R1 reset again");
    nxt(); nmi_in = 1;
    nxt(); insn_last = 1; want(0, -1, -1, -1, -1, -1, -1, "R5 blocked again after reset");
    nxt();
    @(negedge clk);
    #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule